// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block is the host side of a classic eight-bit parallel printer link. A processor reaches it over a small synchronous register bus with its own chip select. Three byte-wide registers are visible there: a data register that either drives the printer data lines or samples them, a status register that reports the printer's handshake inputs, and a control register that sets the four handshake outputs, the data-line direction and the interrupt mask.

All printer-side inputs pass through a synchronizer chain of `SYNC_STAGES` flops before anything uses them. The printer's acknowledge pulse is turned into an interrupt in one of two ways, picked by a mode pin. In pass-through mode the interrupt simply mirrors the acknowledge level. In latched mode a falling acknowledge edge sets a pending flag, which holds the interrupt high until software reads the status register.

The register bus is a plain strobe interface with no back-pressure. A write or read strobe is taken on the rising clock edge at which `bus_cs` is high. Read data appears on `bus_rdata` after that edge and holds until the next read. Pad tristate control is left to the level above, through `pd_oe`.

Top module: `lpt_port`

## Requirements
- R1: After reset, `strobe_n_o`, `autofd_n_o`, `init_n_o` and `slctin_n_o` are 1, `pd_oe` is 0, `pd_out` is 0, `irq_o` is 0, and a read of the control register (offset 2) returns 0.
- R2: A write to offset 0 stores the byte, and it is shown on `pd_out` after that edge. Control bit 5 set to 1 makes `pd_oe` 1, meaning the port drives the lines. Set to 0, the port samples them.
- R3: A read of offset 0 returns `pd_in` after synchronization when control bit 5 is 0. It returns the stored data byte when control bit 5 is 1.
- R4: Control bits 0, 1, 2 and 3 each drive their active-low pin low when set to 1 and high when 0. Bit 0 drives `strobe_n_o`, bit 1 drives `autofd_n_o`, bit 2 drives `init_n_o` and bit 3 drives `slctin_n_o`.
- R5: A read of offset 2 returns bits 5:0 as last written, with bits 7:6 reading 0.
- R6: A read of offset 1 returns synchronized input levels and the pending flag: bit 0 `busy_i`, bit 1 `ack_n_i`, bit 2 `slct_i`, bit 3 `err_n_i`, bit 4 the pending flag. Bits 7:5 read 0.
- R7: Control bit 4 set to 0 holds `irq_o` at 0 whatever the acknowledge input or pending flag do.
- R8: With `irq_mode_i` = 0 and bit 4 set, `irq_o` is 1 while `ack_n_i` is low and 0 while it is high.
- R9: With `irq_mode_i` = 1, a falling edge of `ack_n_i` sets the pending flag. With bit 4 set, `irq_o` is then 1 and stays 1 after `ack_n_i` returns high.
- R10: A read of offset 1 clears the pending flag unless a new falling edge is detected on the same cycle. The read returns the flag's value from before the clear.
- R11: Bus strobes with `bus_cs` = 0 change no register. Writes to offset 3 have no effect, and reads of offset 3 return 0.
- R12: With `irq_mode_i` = 0, acknowledge edges never set the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Chip select for this port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pd_in | input | 8 | Printer data lines as sampled at the pads |
| pd_out | output | 8 | Printer data to drive |
| pd_oe | output | 1 | 1 = drive printer data lines |
| busy_i | input | 1 | Printer busy |
| ack_n_i | input | 1 | Printer acknowledge, active low |
| slct_i | input | 1 | Printer selected |
| err_n_i | input | 1 | Printer error, active low |
| irq_mode_i | input | 1 | 0 = pass-through interrupt, 1 = latched |
| strobe_n_o | output | 1 | Data strobe, active low |
| autofd_n_o | output | 1 | Auto line feed, active low |
| init_n_o | output | 1 | Printer initialize, active low |
| slctin_n_o | output | 1 | Select-in, active low |
| irq_o | output | 1 | Printer interrupt, active high |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. It waits five cycles after every input change, which is more than the synchronizer and edge-detector latency. With this depth the pending flag is set three edges after an acknowledge fall, so it can be cleared by a status read and watched on `irq_o` within a few cycles. This makes both interrupt modes, the mask and the clear-on-read behaviour observable at the ports. Direction switching is covered by reading the data offset with the port driving and with it sampling different values on `pd_in`.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 2;

  localparam logic [OFS_W-1:0] OFS_DATA = 2'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 2'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 2'd2;

  // control register layout, LSB last
  typedef struct packed {
    logic [1:0] spare;
    logic       drive;
    logic       irq_en;
    logic       sel_in;
    logic       init;
    logic       autofd;
    logic       strobe;
  } lpt_ctrl_t;

  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h3F;

  // synchronized input bundle
  typedef struct packed {
    logic              mode;
    logic              err_n;
    logic              slct;
    logic              ack_n;
    logic              busy;
    logic [BYTE_W-1:0] pd;
  } lpt_in_t;

  localparam int IN_W = $bits(lpt_in_t);
  localparam logic [IN_W-1:0] IN_RST = {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, {BYTE_W{1'b0}}};
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int                W      = 4,
  parameter int                STAGES = 2,
  parameter logic [W-1:0]      RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                wr,
  input  logic                rd,
  input  logic [OFS_W-1:0]    addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  input  logic [BYTE_W-1:0]   pd_s,
  input  logic [BYTE_W-1:0]   stat_byte,
  output lpt_ctrl_t           ctrl,
  output logic [BYTE_W-1:0]   pd_latch,
  output logic                stat_rd
);
  logic wr_hit, rd_hit, wr_ctrl, wr_data;
  logic [BYTE_W-1:0] rd_mux;

  assign wr_hit  = cs && wr;
  assign rd_hit  = cs && rd;
  assign wr_ctrl = wr_hit && (addr == OFS_CTRL);
  assign wr_data = wr_hit && (addr == OFS_DATA);
  assign stat_rd = rd_hit && (addr == OFS_STAT);

  always_comb begin
    unique case (addr)
      OFS_DATA: rd_mux = ctrl.drive ? pd_latch : pd_s;
      OFS_STAT: rd_mux = stat_byte;
      OFS_CTRL: rd_mux = ctrl;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      pd_latch <= '0;
      rdata    <= '0;
    end else begin
      if (wr_ctrl) ctrl     <= lpt_ctrl_t'(wdata & CTRL_MASK);
      if (wr_data) pd_latch <= wdata;
      if (rd_hit)  rdata    <= rd_mux;
    end
  end

  a_r2_data_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (pd_latch == $past(wdata)));
  a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl));
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(rdata));
endmodule

// File: rtl/lpt_irq.sv
module lpt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_s,
  input  logic mode_s,
  input  logic irq_en,
  input  logic clr,
  output logic pending,
  output logic irq
);
  logic ack_d, fall, set;

  assign fall = ack_d && !ack_n_s;
  assign set  = fall && mode_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d   <= 1'b1;
      pending <= 1'b0;
    end else begin
      ack_d <= ack_n_s;
      if (set)      pending <= 1'b1;
      else if (clr) pending <= 1'b0;
    end
  end

  assign irq = irq_en && (mode_s ? pending : !ack_n_s);

  a_r9_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && ack_d && !ack_n_s) |=> pending);
  a_r9_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> pending);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(mode_s && ack_d && !ack_n_s)) |=> !pending);
  a_r12_normal_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && !pending) |=> !pending);
endmodule

// File: rtl/lpt_port.sv
module lpt_port
  import lpt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  pd_in,
  output logic [7:0]  pd_out,
  output logic        pd_oe,
  input  logic        busy_i,
  input  logic        ack_n_i,
  input  logic        slct_i,
  input  logic        err_n_i,
  input  logic        irq_mode_i,
  output logic        strobe_n_o,
  output logic        autofd_n_o,
  output logic        init_n_o,
  output logic        slctin_n_o,
  output logic        irq_o
);
  lpt_in_t   raw, syn;
  lpt_ctrl_t ctrl;
  logic      pending, stat_rd;
  logic [BYTE_W-1:0] stat_byte;

  assign raw = '{mode: irq_mode_i, err_n: err_n_i, slct: slct_i,
                 ack_n: ack_n_i, busy: busy_i, pd: pd_in};

  lpt_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  // status layout: bit0 busy, bit1 ack_n, bit2 slct, bit3 err_n, bit4 pending
  assign stat_byte = {3'b000, pending, syn.err_n, syn.slct, syn.ack_n, syn.busy};

  lpt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cs(bus_cs), .wr(bus_wr), .rd(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .pd_s(syn.pd), .stat_byte(stat_byte), .ctrl(ctrl),
    .pd_latch(pd_out), .stat_rd(stat_rd)
  );

  lpt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ack_n_s(syn.ack_n), .mode_s(syn.mode),
    .irq_en(ctrl.irq_en), .clr(stat_rd), .pending(pending), .irq(irq_o)
  );

  assign pd_oe      = ctrl.drive;
  assign strobe_n_o = !ctrl.strobe;
  assign autofd_n_o = !ctrl.autofd;
  assign init_n_o   = !ctrl.init;
  assign slctin_n_o = !ctrl.sel_in;

  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.irq_en) |-> !irq_o);
  a_r4_selin_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_wr && bus_addr == OFS_CTRL) |=> (slctin_n_o == !$past(bus_wdata[3])));
endmodule

// File: tb/test_lpt_port.sv
`timescale 1ns/1ps
module test_lpt_port;
  logic clk = 0, rst_n = 0;
  logic bus_cs = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, pd_in = 0, pd_out;
  logic pd_oe, busy_i = 0, ack_n_i = 1, slct_i = 0, err_n_i = 1, irq_mode_i = 0;
  logic strobe_n_o, autofd_n_o, init_n_o, slctin_n_o, irq_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpt_port i_lpt_port (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(logic [1:0] a, logic [7:0] d, logic cs = 1);
    @(negedge clk); bus_cs = cs; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_cs = 0; bus_wr = 0;
  endtask

  task automatic bread(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_cs = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_cs = 0; bus_rd = 0; d = bus_rdata;
  endtask

  task automatic settle(); repeat (5) @(negedge clk); endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 strobe_n", strobe_n_o, 1); check("R1 autofd_n", autofd_n_o, 1);
    check("R1 init_n", init_n_o, 1); check("R1 slctin_n", slctin_n_o, 1);
    check("R1 pd_oe", pd_oe, 0); check("R1 pd_out", pd_out, 0); check("R1 irq", irq_o, 0);
    bread(2, v); check("R1 ctrl", v, 8'h00);
  endtask

  task automatic t_ctrl_pins();
    logic [7:0] v;
    bwrite(2, 8'h05);
    check("R4 strobe_n", strobe_n_o, 0); check("R4 autofd_n", autofd_n_o, 1);
    check("R4 init_n", init_n_o, 0); check("R4 slctin_n", slctin_n_o, 1);
    bwrite(2, 8'hCA);
    check("R4 strobe_n b", strobe_n_o, 1); check("R4 autofd_n b", autofd_n_o, 0);
    check("R4 init_n b", init_n_o, 1); check("R4 slctin_n b", slctin_n_o, 0);
    bread(2, v); check("R5 ctrl readback", v, 8'h0A);
    bwrite(2, 8'h00);
  endtask

  task automatic t_data();
    logic [7:0] v;
    bwrite(0, 8'hA5); check("R2 pd_out", pd_out, 8'hA5);
    pd_in = 8'h3C; settle();
    bread(0, v); check("R3 sampled", v, 8'h3C);
    bwrite(2, 8'h20); check("R2 pd_oe", pd_oe, 1);
    bread(0, v); check("R3 driven", v, 8'hA5);
    bwrite(2, 8'h00); check("R2 pd_oe off", pd_oe, 0);
  endtask

  task automatic t_status();
    logic [7:0] v;
    busy_i = 1; ack_n_i = 1; slct_i = 0; err_n_i = 0; settle();
    bread(1, v); check("R6 status a", v, 8'h03);
    busy_i = 0; slct_i = 1; err_n_i = 1; settle();
    bread(1, v); check("R6 status b", v, 8'h0E);
  endtask

  task automatic t_irq_normal();
    logic [7:0] v;
    irq_mode_i = 0; bwrite(2, 8'h10); settle();
    check("R8 idle", irq_o, 0);
    ack_n_i = 0; settle(); check("R8 ack low", irq_o, 1);
    bread(1, v); check("R12 no pending", v[4], 0);
    ack_n_i = 1; settle(); check("R8 ack high", irq_o, 0);
    bread(1, v); check("R12 no pending after", v[4], 0);
  endtask

  task automatic t_irq_latched();
    logic [7:0] v;
    irq_mode_i = 1; settle();
    ack_n_i = 0; settle(); check("R9 set", irq_o, 1);
    ack_n_i = 1; settle(); check("R9 held", irq_o, 1);
    bread(1, v); check("R10 read shows pending", v[4], 1);
    check("R10 cleared irq", irq_o, 0);
    bread(1, v); check("R10 cleared flag", v[4], 0);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    bwrite(2, 8'h00);
    ack_n_i = 0; settle(); check("R7 masked low", irq_o, 0);
    ack_n_i = 1; settle(); check("R7 masked after", irq_o, 0);
    bread(1, v); check("R7 pending still recorded", v[4], 1);
    irq_mode_i = 0; bwrite(2, 8'h10); ack_n_i = 0; settle();
    bwrite(2, 8'h00); check("R7 mask normal", irq_o, 0);
    ack_n_i = 1; settle();
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    bwrite(2, 8'h0F, 0);
    check("R11 cs low strobe_n", strobe_n_o, 1);
    bwrite(0, 8'h77, 0); check("R11 cs low data", pd_out, 8'hA5);
    bwrite(3, 8'h0F);
    bread(2, v); check("R11 offset3 write", v, 8'h00);
    bread(3, v); check("R11 offset3 read", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_ctrl_pins(); t_data(); t_status();
    t_irq_normal(); t_irq_latched(); t_mask(); t_ignore();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule